// File: doc/BRIEF.md
# Four-Bank Memory Page Mapper

This block sits between an 8-bit CPU and a 1 MiB physical store made of a 512 KiB ROM and a 512 KiB RAM. The CPU sees 64 KiB of logical address space, cut into four 16 KiB banks by the top two address bits. Each bank has its own page-select register that names one of the 16 KiB physical pages. A separate enable register switches the translation on. Until software sets that register, every bank shows the first ROM page, which holds the boot code.

Software writes the registers with I/O port cycles in the 78h–7Fh window. The low half of that window holds the four page registers and the high half holds the enable bit. The registers cannot be read back. A register write takes effect on the clock edge that ends the write strobe. On every memory request, the mapper turns the logical address into physical address lines 18:14 and an active-low select for the ROM or for the RAM. Its outputs are registered, so they follow the request by one clock.

Top module: `bank_page_mapper`

## Requirements
- R1: After a synchronous reset, paging is disabled, both chip selects are high (inactive) and the physical page lines are zero.
- R2: While paging is disabled, every memory request in any bank selects the ROM with page lines zero, whatever the page registers hold.
- R3: Logical address bits 15:14 pick the bank: 0 for 0000h–3FFFh, 1 for 4000h–7FFFh, 2 for 8000h–BFFFh and 3 for C000h–FFFFh.
- R4: An I/O write to port 78h+n (n = 0..3) loads the 8-bit page register of bank n. The write commits on the first clock edge at which the strobe is sampled low after being high, using the port and data seen while the strobe was high. Output translation changes one clock after that edge.
- R5: An I/O write to any of ports 7Ch–7Fh sets paging on when data bit 0 is 1 and off when it is 0. Data bits 7:1 have no effect.
- R6: With paging on, a page value whose bits 6:5 are 00 selects the ROM, and page lines 18:14 equal page bits 4:0.
- R7: With paging on, a page value whose bits 6:5 are 01 selects the RAM, and page lines equal page bits 4:0. The ROM and RAM selects are never low together.
- R8: A page value with bit 6 set selects neither chip. Bit 7 of a page value has no effect.
- R9: Neither chip select is low in a cycle that follows a clock edge where the memory request was low.
- R10: I/O writes to ports outside 78h–7Fh change neither the page registers nor the enable bit.
- R11: Chip selects and page lines are registered: they reflect the request and address sampled on the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | I/O write strobe, active high |
| io_port | input | 8 | I/O port address |
| io_data | input | 8 | I/O write data |
| mem_req | input | 1 | Memory request, active high |
| mem_addr | input | 16 | Logical CPU address |
| phys_page | output | 5 | Physical address lines 18:14 |
| rom_cs_n | output | 1 | ROM chip select, active low |
| ram_cs_n | output | 1 | RAM chip select, active low |

## Verification
The hardest case to reach from the ports is the moment a page register changes while a request to the same bank is already in flight. The write must not act while the strobe is held, and the mapped result must switch exactly one clock after the strobe falls. The bench holds the strobe high for several cycles with a request to the bank being rewritten. It checks the old mapping on each of those cycles, then checks the cycle of the commit and the one after it. A second hard case is showing that registers with no defined value are masked while paging is off. The bench fills them with RAM and reserved pages before it sets the enable bit, and checks that every bank still gives ROM page 0.

// File: rtl/mpm_pkg.sv
package mpm_pkg;
  // Which physical device a decoded page lands on.
  typedef enum logic [1:0] {
    REGION_ROM  = 2'd0,
    REGION_RAM  = 2'd1,
    REGION_NONE = 2'd2
  } region_e;

  // Default geometry of the mapper.
  localparam int unsigned CPU_ADDR_W  = 16;
  localparam int unsigned BANK_BITS   = 2;
  localparam int unsigned PAGE_W      = 8;
  localparam int unsigned PAGE_LINE_W = 5;
  localparam int unsigned IO_PORT_W   = 8;
  localparam int unsigned IO_DATA_W   = 8;
endpackage

// File: rtl/mpm_io_decode.sv
module mpm_io_decode #(
  parameter int unsigned          PORT_W    = 8,
  parameter int unsigned          DATA_W    = 8,
  parameter int unsigned          BANK_BITS = 2,
  parameter logic [PORT_W-BANK_BITS-2:0] WINDOW_TAG = '1 >> 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 io_wr,
  input  logic [PORT_W-1:0]    io_port,
  input  logic [DATA_W-1:0]    io_data,
  output logic                 wr_page,
  output logic                 wr_enable,
  output logic [BANK_BITS-1:0] wr_bank,
  output logic [DATA_W-1:0]    wr_data
);
  // Bit just above the bank index splits page writes from enable writes.
  localparam int unsigned KIND_BIT = BANK_BITS;
  localparam int unsigned TAG_LO   = BANK_BITS + 1;

  logic              strobe_q;
  logic [PORT_W-1:0] port_q;
  logic [DATA_W-1:0] data_q;
  logic              commit;
  logic              in_window;

  // Keep the last port/data seen with the strobe high.
  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b0;
      port_q   <= '0;
      data_q   <= '0;
    end else begin
      strobe_q <= io_wr;
      if (io_wr) begin
        port_q <= io_port;
        data_q <= io_data;
      end
    end
  end

  always_comb begin
    commit    = strobe_q && !io_wr;
    in_window = (port_q[PORT_W-1:TAG_LO] == WINDOW_TAG);
    wr_page   = commit && in_window && !port_q[KIND_BIT];
    wr_enable = commit && in_window &&  port_q[KIND_BIT];
    wr_bank   = port_q[BANK_BITS-1:0];
    wr_data   = data_q;
  end
endmodule

// File: rtl/mpm_page_file.sv
module mpm_page_file #(
  parameter int unsigned BANK_BITS = 2,
  parameter int unsigned PAGE_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_page,
  input  logic                 wr_enable,
  input  logic [BANK_BITS-1:0] wr_bank,
  input  logic [PAGE_W-1:0]    wr_data,
  input  logic [BANK_BITS-1:0] rd_bank,
  output logic [PAGE_W-1:0]    rd_page,
  output logic                 paging_on
);
  localparam int unsigned NUM_BANKS = 1 << BANK_BITS;

  logic [PAGE_W-1:0] page_q [NUM_BANKS];

  // Page registers have no reset: their content is undefined until written.
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (wr_page && (wr_bank == BANK_BITS'(b))) begin
        page_q[b] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      paging_on <= 1'b0;
    end else if (wr_enable) begin
      paging_on <= wr_data[0];
    end
  end

  assign rd_page = page_q[rd_bank];
endmodule

// File: rtl/mpm_xlate.sv
module mpm_xlate #(
  parameter int unsigned PAGE_W      = 8,
  parameter int unsigned PAGE_LINE_W = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   mem_req,
  input  logic                   paging_on,
  input  logic [PAGE_W-1:0]      page_in,
  output logic [PAGE_LINE_W-1:0] phys_page,
  output logic                   rom_cs_n,
  output logic                   ram_cs_n
);
  import mpm_pkg::*;

  // Bit above the address lines picks RAM, the next one reserves space.
  localparam int unsigned RAM_BIT = PAGE_LINE_W;
  localparam int unsigned RSV_BIT = PAGE_LINE_W + 1;

  function automatic region_e classify(input logic [PAGE_W-1:0] pg);
    if (pg[RSV_BIT])      return REGION_NONE;
    else if (pg[RAM_BIT]) return REGION_RAM;
    else                  return REGION_ROM;
  endfunction

  logic [PAGE_W-1:0] eff_page;
  region_e           region;

  always_comb begin
    eff_page = paging_on ? page_in : '0;
    region   = classify(eff_page);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phys_page <= '0;
      rom_cs_n  <= 1'b1;
      ram_cs_n  <= 1'b1;
    end else begin
      phys_page <= eff_page[PAGE_LINE_W-1:0];
      rom_cs_n  <= !(mem_req && (region == REGION_ROM));
      ram_cs_n  <= !(mem_req && (region == REGION_RAM));
    end
  end
endmodule

// File: rtl/bank_page_mapper.sv
module bank_page_mapper
  import mpm_pkg::*;
#(
  parameter int unsigned ADDR_W   = CPU_ADDR_W,
  parameter int unsigned BANK_W   = BANK_BITS,
  parameter int unsigned PG_W     = PAGE_W,
  parameter int unsigned PLINE_W  = PAGE_LINE_W,
  parameter int unsigned PORT_W   = IO_PORT_W,
  parameter int unsigned DATA_W   = IO_DATA_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               io_wr,
  input  logic [PORT_W-1:0]  io_port,
  input  logic [DATA_W-1:0]  io_data,
  input  logic               mem_req,
  input  logic [ADDR_W-1:0]  mem_addr,
  output logic [PLINE_W-1:0] phys_page,
  output logic               rom_cs_n,
  output logic               ram_cs_n
);
  localparam int unsigned TAG_W = PORT_W - BANK_W - 1;
  localparam logic [TAG_W-1:0] WINDOW = TAG_W'(8'h78 >> (BANK_W + 1));

  logic              wr_page;
  logic              wr_enable;
  logic [BANK_W-1:0] wr_bank;
  logic [DATA_W-1:0] wr_data;
  logic [PG_W-1:0]   bank_page;
  logic              paging_on;
  logic [BANK_W-1:0] cur_bank;

  assign cur_bank = mem_addr[ADDR_W-1 -: BANK_W];

  mpm_io_decode #(
    .PORT_W    (PORT_W),
    .DATA_W    (DATA_W),
    .BANK_BITS (BANK_W),
    .WINDOW_TAG(WINDOW)
  ) u_decode (
    .clk      (clk),
    .rst      (rst),
    .io_wr    (io_wr),
    .io_port  (io_port),
    .io_data  (io_data),
    .wr_page  (wr_page),
    .wr_enable(wr_enable),
    .wr_bank  (wr_bank),
    .wr_data  (wr_data)
  );

  mpm_page_file #(
    .BANK_BITS(BANK_W),
    .PAGE_W   (PG_W)
  ) u_pages (
    .clk      (clk),
    .rst      (rst),
    .wr_page  (wr_page),
    .wr_enable(wr_enable),
    .wr_bank  (wr_bank),
    .wr_data  (PG_W'(wr_data)),
    .rd_bank  (cur_bank),
    .rd_page  (bank_page),
    .paging_on(paging_on)
  );

  mpm_xlate #(
    .PAGE_W     (PG_W),
    .PAGE_LINE_W(PLINE_W)
  ) u_xlate (
    .clk      (clk),
    .rst      (rst),
    .mem_req  (mem_req),
    .paging_on(paging_on),
    .page_in  (bank_page),
    .phys_page(phys_page),
    .rom_cs_n (rom_cs_n),
    .ram_cs_n (ram_cs_n)
  );
endmodule

// File: rtl/mpm_checker.sv
module mpm_checker #(
  parameter int unsigned PLINE_W = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               io_wr,
  input logic               mem_req,
  input logic               paging_on,
  input logic [PLINE_W-1:0] phys_page,
  input logic               rom_cs_n,
  input logic               ram_cs_n
);
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (rom_cs_n && ram_cs_n && !paging_on && phys_page == '0));

  p_disabled_rom0_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(mem_req) && !$past(paging_on) && !$past(rst))
      |-> (!rom_cs_n && ram_cs_n && phys_page == '0));

  p_enable_at_strobe_end_r4: assert property (@(posedge clk) disable iff (rst)
    (!$stable(paging_on) && !$past(rst))
      |-> ($past(io_wr, 2) && !$past(io_wr)));

  p_single_select_r7: assert property (@(posedge clk) disable iff (rst)
    !(!rom_cs_n && !ram_cs_n));

  p_idle_without_req_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(mem_req) |-> (rom_cs_n && ram_cs_n));
endmodule

bind bank_page_mapper mpm_checker #(.PLINE_W(PLINE_W)) u_mpm_checker (
  .clk      (clk),
  .rst      (rst),
  .io_wr    (io_wr),
  .mem_req  (mem_req),
  .paging_on(paging_on),
  .phys_page(phys_page),
  .rom_cs_n (rom_cs_n),
  .ram_cs_n (ram_cs_n)
);

// File: tb/bank_page_mapper_bench.sv
module bank_page_mapper_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       io_wr = 1'b0;
  logic [7:0] io_port = 8'h00;
  logic [7:0] io_data = 8'h00;
  logic       mem_req = 1'b0;
  logic [15:0] mem_addr = 16'h0000;
  logic [4:0] phys_page;
  logic       rom_cs_n;
  logic       ram_cs_n;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model_pg [4];
  logic       model_en = 1'b0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  bank_page_mapper u_bank_page_mapper (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_port(io_port), .io_data(io_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .phys_page(phys_page),
    .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n)
  );

  task automatic check3(input string req, input logic [4:0] ep,
                        input logic erom, input logic eram);
    checks++;
    if (phys_page !== ep || rom_cs_n !== erom || ram_cs_n !== eram) begin
      fails++;
      $display("FAIL %s: got page=%0d rom_n=%b ram_n=%b, expected page=%0d rom_n=%b ram_n=%b",
               req, phys_page, rom_cs_n, ram_cs_n, ep, erom, eram);
    end
  endtask

  // Starts and ends at a falling edge.
  task automatic io_write(input logic [7:0] port, input logic [7:0] data);
    io_wr = 1'b1; io_port = port; io_data = data;
    @(negedge clk);
    io_wr = 1'b0; io_port = 8'h00; io_data = 8'h00;
    @(negedge clk);
    if (port[7:3] == 5'b01111) begin
      if (port[2]) model_en = data[0];
      else         model_pg[port[1:0]] = data;
    end
  endtask

  // Expected outputs computed from the model state.
  task automatic mem_check(input string req, input logic [15:0] addr);
    logic [7:0] pg;
    logic erom, eram;
    mem_req = 1'b1; mem_addr = addr;
    @(negedge clk);
    pg = model_en ? model_pg[addr[15:14]] : 8'h00;
    erom = !(pg[6] == 1'b0 && pg[5] == 1'b0);
    eram = !(pg[6] == 1'b0 && pg[5] == 1'b1);
    check3(req, pg[4:0], erom, eram);
    mem_req = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check3("R1", 5'd0, 1'b1, 1'b1);
    rst = 1'b0;
    @(negedge clk);
    check3("R1", 5'd0, 1'b1, 1'b1);

    // R2: load RAM/reserved pages while paging is off; all banks still ROM page 0
    io_write(8'h78, 8'h2A);
    io_write(8'h79, 8'h45);
    io_write(8'h7A, 8'h3F);
    io_write(8'h7B, 8'hA7);
    for (int b = 0; b < 4; b++) begin
      mem_check("R2", {b[1:0], 14'h1234});
      mem_check("R2", {b[1:0], 14'h3FFF});
    end

    // R5: enable via alias 7Dh with other bits zero
    io_write(8'h7D, 8'h01);
    for (int b = 0; b < 4; b++) mem_check("R5", {b[1:0], 14'h0000});

    // R3/R6/R7/R8: sweep all 256 page values over the four banks
    for (int v = 0; v < 256; v++) begin
      for (int b = 0; b < 4; b++) io_write(8'h78 + 8'(b), 8'((v + 37 * b) % 256));
      for (int b = 0; b < 4; b++) begin
        mem_check("R3_R6_R7_R8", {b[1:0], 14'(v * 61)});
      end
    end

    // R9: no request, no select
    io_write(8'h78, 8'h21);
    mem_req = 1'b0; mem_addr = 16'h0000;
    @(negedge clk);
    check3("R9", 5'd1, 1'b1, 1'b1);

    // R4/R11: strobe held high with a live request to the bank being rewritten
    io_write(8'h78, 8'h05);
    mem_req = 1'b1; mem_addr = 16'h0100;
    io_wr = 1'b1; io_port = 8'h78; io_data = 8'h33;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check3("R4 hold", 5'd5, 1'b0, 1'b1);
    end
    io_wr = 1'b0;
    @(negedge clk);
    check3("R11 commit edge", 5'd5, 1'b0, 1'b1);
    @(negedge clk);
    check3("R4 after commit", 5'd19, 1'b1, 1'b0);
    mem_req = 1'b0;
    model_pg[0] = 8'h33;

    // R10: writes outside the window are ignored
    io_write(8'h70, 8'h00);
    io_write(8'h80, 8'h00);
    io_write(8'hF8, 8'h00);
    io_write(8'h3C, 8'h00);
    io_write(8'h77, 8'h00);
    mem_check("R10", 16'h0000);
    if (!model_en) begin fails++; $display("FAIL R10: model disabled, expected enabled"); end

    // R5: bits 7:1 ignored, bit 0 clear disables (alias 7Fh)
    io_write(8'h7F, 8'hFE);
    for (int b = 0; b < 4; b++) mem_check("R5", {b[1:0], 14'h2000});
    io_write(8'h7E, 8'hFF);
    mem_check("R5", 16'h0000);

    // R1: reset again disables paging
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check3("R1", 5'd0, 1'b1, 1'b1);
    rst = 1'b0;
    model_en = 1'b0;
    mem_check("R1", 16'hC000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule